// File: doc/BRIEF.md
# Immediate-Operand Execution Unit

This block carries out the immediate-form arithmetic and logic operations of a 32-bit load-store core. It owns a 32 x 32-bit register file. On each clock edge where the valid strobe is high, it decodes the instruction word and reads the source register. It combines that register with the 16-bit constant held in the instruction and writes the result into the destination register. Memory operations, branches, register-to-register operations and overflow exceptions are outside its scope.

Each opcode treats the constant in its own way. Add and set-less-than sign-extend it. OR zero-extends it. Load-upper moves it into the top half of the word. A load-upper followed by an OR into the same register can therefore build any 32-bit value. A combinational debug port reads any register at any time, and it shows a new write from the clock edge that performs it.

Top module: `imm_exec_unit`

## Requirements
- R1: While reset is low, every register is cleared to zero, and every register reads zero after reset is released, including when reset is asserted in the middle of operation.
- R2: The instruction fields are opcode [31:26], source register [25:21], destination register [20:16] and constant [15:0]. The destination field selects the register written, so an instruction with opcode 8, source 29, destination 29 and constant 4 adds 4 to register 29.
- R3: Opcode 8 writes the source register plus the sign-extended constant, and a result that overflows wraps modulo 2^32.
- R4: Opcode 10 writes 1 when the source register, taken as signed, is less than the sign-extended constant, and writes 0 otherwise. Bits 31:1 of the result are always zero.
- R5: Opcode 13 writes the bitwise OR of the source register and the zero-extended constant.
- R6: Opcode 15 writes the constant into bits 31:16 and zeros into bits 15:0, and the source field is ignored.
- R7: A load-upper followed by an OR-immediate into the same register leaves that register holding the full 32-bit constant.
- R8: Register 0 always reads zero, and a write that targets it is discarded.
- R9: A valid instruction whose opcode is not 8, 10, 13 or 15 leaves all registers unchanged.
- R10: While valid is low, all registers stay unchanged.
- R11: A result is written on the rising clock edge on which valid is high, and it is visible on the debug port from that edge onward and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 32 | Instruction word |
| dbg_addr_i | input | 5 | Debug read register index |
| dbg_data_o | output | 32 | Contents of the register selected by dbg_addr_i |

## Verification
A bad decode or a bad write enable puts a wrong value into a register. The debug port shows that value from the clock edge that wrote it, so a check that reads the destination straight after the instruction catches the fault within one cycle. A bad register 0 or a spurious write shows up as a change in a register that should have held its value, and the bench catches it when it reads that register back later. The constant-building pairs and the wrap case produce values whose every bit depends on the extension mode, so a wrong sign or zero fill is visible in the high half at once.

// File: rtl/imm_exec_pkg.sv
package imm_exec_pkg;
  localparam int unsigned XLEN     = 32;
  localparam int unsigned NREGS    = 32;
  localparam int unsigned RIDX_W   = $clog2(NREGS);
  localparam int unsigned OPC_W    = 6;
  localparam int unsigned CONST_W  = 16;
  localparam int unsigned OPC_LSB  = XLEN - OPC_W;
  localparam int unsigned SRC_LSB  = OPC_LSB - RIDX_W;
  localparam int unsigned DST_LSB  = SRC_LSB - RIDX_W;

  localparam logic [OPC_W-1:0] OPC_ADDI = 6'd8;
  localparam logic [OPC_W-1:0] OPC_SLTI = 6'd10;
  localparam logic [OPC_W-1:0] OPC_ORI  = 6'd13;
  localparam logic [OPC_W-1:0] OPC_LUI  = 6'd15;

  typedef enum logic [2:0] {
    K_NONE, K_ADD, K_SLT, K_OR, K_UPPER
  } op_kind_e;

  typedef struct packed {
    op_kind_e          kind;
    logic [RIDX_W-1:0] src;
    logic [RIDX_W-1:0] dst;
    logic [XLEN-1:0]   opnd;
  } dec_t;
endpackage

// File: rtl/imm_decode.sv
module imm_decode
  import imm_exec_pkg::*;
(
  input  logic [XLEN-1:0] instr_i,
  output dec_t            dec_o
);
  logic [OPC_W-1:0]   opc;
  logic [CONST_W-1:0] cst;

  assign opc = instr_i[XLEN-1 -: OPC_W];
  assign cst = instr_i[CONST_W-1:0];

  always_comb begin
    dec_o.src = instr_i[SRC_LSB +: RIDX_W];
    dec_o.dst = instr_i[DST_LSB +: RIDX_W];
    unique case (opc)
      OPC_ADDI: begin
        dec_o.kind = K_ADD;
        dec_o.opnd = {{(XLEN-CONST_W){cst[CONST_W-1]}}, cst};
      end
      OPC_SLTI: begin
        dec_o.kind = K_SLT;
        dec_o.opnd = {{(XLEN-CONST_W){cst[CONST_W-1]}}, cst};
      end
      OPC_ORI: begin
        dec_o.kind = K_OR;
        dec_o.opnd = {{(XLEN-CONST_W){1'b0}}, cst};
      end
      OPC_LUI: begin
        dec_o.kind = K_UPPER;
        dec_o.opnd = {cst, {(XLEN-CONST_W){1'b0}}};
      end
      default: begin
        dec_o.kind = K_NONE;
        dec_o.opnd = '0;
      end
    endcase
  end
endmodule

// File: rtl/imm_alu.sv
module imm_alu
  import imm_exec_pkg::*;
(
  input  op_kind_e        kind_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [XLEN-1:0] opnd_i,
  output logic [XLEN-1:0] res_o,
  output logic            wr_ok_o
);
  always_comb begin
    wr_ok_o = 1'b1;
    unique case (kind_i)
      K_ADD:   res_o = src_i + opnd_i;
      K_SLT:   res_o = {{(XLEN-1){1'b0}}, ($signed(src_i) < $signed(opnd_i))};
      K_OR:    res_o = src_i | opnd_i;
      K_UPPER: res_o = opnd_i;
      default: begin
        res_o   = '0;
        wr_ok_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/imm_regfile.sv
module imm_regfile
  import imm_exec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [RIDX_W-1:0] waddr_i,
  input  logic [XLEN-1:0]   wdata_i,
  input  logic [RIDX_W-1:0] raddr_a_i,
  output logic [XLEN-1:0]   rdata_a_o,
  input  logic [RIDX_W-1:0] raddr_b_i,
  output logic [XLEN-1:0]   rdata_b_o
);
  logic [XLEN-1:0] regs_q [NREGS];

  // entry 0 is hardwired; only entries 1.. are storage
  assign regs_q[0] = '0;

  for (genvar g = 1; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   regs_q[g] <= '0;
      else if (we_i && waddr_i == RIDX_W'(g))        regs_q[g] <= wdata_i;
    end
  end

  assign rdata_a_o = regs_q[raddr_a_i];
  assign rdata_b_o = regs_q[raddr_b_i];
endmodule

// File: rtl/imm_exec_unit.sv
module imm_exec_unit
  import imm_exec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [XLEN-1:0]   instr_i,
  input  logic [RIDX_W-1:0] dbg_addr_i,
  output logic [XLEN-1:0]   dbg_data_o
);
  dec_t            dec;
  logic [XLEN-1:0] src_val;
  logic [XLEN-1:0] res;
  logic            wr_ok;
  logic            we;

  imm_decode u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  imm_alu u_alu (
    .kind_i  (dec.kind),
    .src_i   (src_val),
    .opnd_i  (dec.opnd),
    .res_o   (res),
    .wr_ok_o (wr_ok)
  );

  assign we = valid_i && wr_ok;

  imm_regfile u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we),
    .waddr_i   (dec.dst),
    .wdata_i   (res),
    .raddr_a_i (dec.src),
    .rdata_a_o (src_val),
    .raddr_b_i (dbg_addr_i),
    .rdata_b_o (dbg_data_o)
  );
endmodule

// File: rtl/imm_exec_unit_chk.sv
module imm_exec_unit_chk
  import imm_exec_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [XLEN-1:0]   instr_i,
  input logic [RIDX_W-1:0] dbg_addr_i,
  input logic [XLEN-1:0]   dbg_data_o
);
  logic [OPC_W-1:0]  opc;
  logic [RIDX_W-1:0] dst;
  logic              known_opc;

  assign opc       = instr_i[XLEN-1 -: OPC_W];
  assign dst       = instr_i[DST_LSB +: RIDX_W];
  assign known_opc = opc inside {OPC_ADDI, OPC_SLTI, OPC_ORI, OPC_LUI};

  p_zero_reg_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_addr_i == '0 |-> dbg_data_o == '0);

  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(valid_i) && $stable(dbg_addr_i)) |-> $stable(dbg_data_o));

  p_bad_opc_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_i) && !$past(known_opc) && $stable(dbg_addr_i)) |-> $stable(dbg_data_o));

  p_upper_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_i) && $past(opc) == OPC_LUI && $past(dst) != '0 && dbg_addr_i == $past(dst))
    |-> dbg_data_o == {$past(instr_i[CONST_W-1:0]), {(XLEN-CONST_W){1'b0}}});

  p_slt_bool_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_i) && $past(opc) == OPC_SLTI && dbg_addr_i == $past(dst))
    |-> dbg_data_o[XLEN-1:1] == '0);
endmodule

bind imm_exec_unit imm_exec_unit_chk u_chk (.*);

// File: tb/imm_exec_unit_tb_top.sv
module imm_exec_unit_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 5000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [4:0]  dbg_addr_i = '0;
  logic [31:0] dbg_data_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  imm_exec_unit dut_i (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [31:0] enc(input int op, input int rs, input int rt, input logic [15:0] k);
    return {op[5:0], rs[4:0], rt[4:0], k};
  endfunction

  typedef struct packed {
    logic [31:0] instr;
    logic [4:0]  addr;
    logic [31:0] exp;
    logic [23:0] req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{{6'd8, 5'd0, 5'd1, 16'd5},      5'd1,  32'h0000_0005, "R3 "}, // r1 = 5
    '{{6'd8, 5'd1, 5'd2, 16'hFFF9},   5'd2,  32'hFFFF_FFFE, "R3 "}, // r2 = 5 + -7
    '{{6'd10, 5'd2, 5'd3, 16'hFFFF},  5'd3,  32'h0000_0001, "R4 "}, // -2 < -1
    '{{6'd10, 5'd1, 5'd4, 16'd5},     5'd4,  32'h0000_0000, "R4 "}, // 5 < 5 false
    '{{6'd10, 5'd1, 5'd5, 16'h8000},  5'd5,  32'h0000_0000, "R4 "}, // 5 < -32768 false
    '{{6'd10, 5'd2, 5'd6, 16'h7FFF},  5'd6,  32'h0000_0001, "R4 "}, // -2 < 32767
    '{{6'd13, 5'd2, 5'd7, 16'h8001},  5'd7,  32'hFFFF_FFFF, "R5 "},
    '{{6'd13, 5'd0, 5'd11, 16'h8000}, 5'd11, 32'h0000_8000, "R5 "}, // zero-extend
    '{{6'd15, 5'd1, 5'd8, 16'h1234},  5'd8,  32'h1234_0000, "R6 "}, // src ignored
    '{{6'd13, 5'd8, 5'd8, 16'hABCD},  5'd8,  32'h1234_ABCD, "R7 "},
    '{{6'd15, 5'd0, 5'd9, 16'hDEAD},  5'd9,  32'hDEAD_0000, "R6 "},
    '{{6'd13, 5'd9, 5'd9, 16'hBEEF},  5'd9,  32'hDEAD_BEEF, "R7 "},
    '{{6'd8, 5'd1, 5'd0, 16'd3},      5'd0,  32'h0000_0000, "R8 "}, // write r0 dropped
    '{{6'd13, 5'd9, 5'd0, 16'hFFFF},  5'd0,  32'h0000_0000, "R8 "},
    '{{6'd35, 5'd0, 5'd1, 16'd9},     5'd1,  32'h0000_0005, "R9 "}, // unsupported op
    '{{6'd15, 5'd0, 5'd10, 16'h7FFF}, 5'd10, 32'h7FFF_0000, "R6 "},
    '{{6'd13, 5'd10, 5'd10, 16'hFFFF},5'd10, 32'h7FFF_FFFF, "R7 "},
    '{{6'd8, 5'd10, 5'd10, 16'd1},    5'd10, 32'h8000_0000, "R3 "}, // wrap
    '{{6'd8, 5'd29, 5'd29, 16'd4},    5'd29, 32'h0000_0004, "R2 "},
    '{{6'd8, 5'd29, 5'd29, 16'd4},    5'd29, 32'h0000_0008, "R2 "}
  };

  task automatic check(input string req, input logic [4:0] a, input logic [31:0] exp);
    dbg_addr_i = a;
    #1;
    n_chk++;
    if (dbg_data_o !== exp) begin
      n_bad++;
      $display("FAIL %s reg%0d actual=%h expected=%h", req, a, dbg_data_o, exp);
    end
  endtask

  task automatic issue(input logic [31:0] ins, input logic v);
    @(negedge clk_i);
    instr_i = ins;
    valid_i = v;
    @(posedge clk_i);
    #1;
    valid_i = 1'b0;
    instr_i = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    // R1: registers read zero out of reset
    check("R1", 5'd0, '0);
    check("R1", 5'd17, '0);
    check("R1", 5'd31, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", 5'd1, '0);
    check("R1", 5'd31, '0);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].instr, 1'b1);
      check(string'(VECS[i].req), VECS[i].addr, VECS[i].exp);
    end

    // R10: valid low leaves registers alone
    issue(enc(8, 0, 1, 16'd99), 1'b0);
    check("R10", 5'd1, 32'h0000_0005);
    issue(enc(15, 0, 9, 16'h5555), 1'b0);
    check("R10", 5'd9, 32'hDEAD_BEEF);

    // R9: other unsupported opcodes with destination r9
    issue(enc(0, 1, 9, 16'h0020), 1'b1);
    check("R9", 5'd9, 32'hDEAD_BEEF);
    issue(enc(43, 1, 9, 16'h0004), 1'b1);
    check("R9", 5'd9, 32'hDEAD_BEEF);

    // R11: not visible before the edge, visible after it
    @(negedge clk_i);
    instr_i = enc(8, 1, 12, 16'd10);
    valid_i = 1'b1;
    check("R11", 5'd12, 32'h0000_0000);
    @(posedge clk_i);
    #1;
    valid_i = 1'b0;
    check("R11", 5'd12, 32'h0000_000F);

    // R8: debug read of r0 after many writes to it
    check("R8", 5'd0, '0);

    // R1: reset in mid-operation clears state
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1", 5'd9, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    check("R1", 5'd8, '0);
    check("R1", 5'd29, '0);

    // R3 after reset: source comes from the freshly cleared file
    issue(enc(8, 8, 2, 16'h8000), 1'b1);
    check("R3", 5'd2, 32'hFFFF_8000);

    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule